// File: doc/BRIEF.md
# Receive Buffer Element Allocator

This block manages the receive-side packet buffer for a 16-bit burst link whose stream interleaves control words and data words. An 8 KB buffer is divided into equal elements whose size is chosen by a configuration input. Each payload control word claims a fresh element from a pool of free indices. The data words that follow are written into that element. The element is closed when another control word arrives or when it is already full and more data comes.

Every closed element is reported as one record. The record carries the element index, the number of valid bytes, whether the element opened a packet (SOP), whether the packet ended in it (EOP), and the port address of the burst. The consumer returns an element to the pool through a release port once it has processed it. Because any control word closes the current element, a short burst still uses a whole element. Throughput on the buffer therefore depends on the sender using bursts that match the element size.

Top module: `rbuf_alloc`

## Requirements
- R1: After reset all elements are free, no write and no record is presented, and `ovf_cnt` is zero. Never-used indices are handed out in ascending order starting at 0.
- R2: `cfg_esize` selects the element size: 0 gives 64 bytes (128 elements), 1 gives 128 bytes (64 elements), 2 or 3 gives 256 bytes (32 elements). `wr_addr` is the 16-bit word address (element index × element bytes + byte offset) / 2.
- R3: A control word (`in_ctl`=1) is decoded as follows. Bit 15 set marks a payload word. Bit 12 is SOP, bits 11:4 are the port, and bits 14:13 are the end status of the preceding burst (1x = EOP; 11 = its last word holds one byte). Bits 3:0 are ignored. A control word with bit 15 clear is an idle or training word: it allocates nothing and writes nothing.
- R4: Each payload control word allocates a fresh element for the following burst and stores its SOP flag and port for the record.
- R5: Any control word closes the open element, even one that is only partly filled. The record's byte count is 2 per data word, less 1 when the end status is 11. Its EOP flag is bit 14 of the closing word.
- R6: A data word that arrives while the open element holds its full capacity closes it with a full byte count and EOP clear. The word then goes to offset 0 of a newly allocated continuation element, which carries SOP clear and the same port.
- R7: When an allocation finds no free element, `ovf_cnt` increments by one. The burst is then dropped: no element is open and its data words are not written.
- R8: Released indices are queued first-in first-out and are handed out, in release order, after the never-used indices are exhausted.
- R9: A data word that arrives with no element open is not written.
- R10: Writes and records appear on the outputs one clock after the input word that causes them.
- R11: A release and an allocation in the same cycle both take effect. The allocation sees the free pool as it stood before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_esize | input | 2 | Element size select |
| in_valid | input | 1 | Input word present |
| in_ctl | input | 1 | Input word is a control word |
| in_word | input | 16 | Control or data word |
| rel_valid | input | 1 | Release an element |
| rel_idx | input | 7 | Index of the released element |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 12 | Buffer word address |
| wr_data | output | 16 | Buffer write data |
| done_valid | output | 1 | Completed-element record valid |
| done_idx | output | 7 | Element index |
| done_bytes | output | 9 | Valid bytes in the element |
| done_sop | output | 1 | Element starts a packet |
| done_eop | output | 1 | Element ends a packet |
| done_port | output | 8 | Port address of the burst |
| ovf_cnt | output | 16 | Count of dropped bursts |

## Verification
Two collisions matter here. The first is an element release landing in the same cycle as an allocation. The bench provokes it twice: once with the pool empty, where the burst must be dropped and the released index is granted at the next payload word, and once with one index queued, where the queued index is granted and the released one follows it. The second is a close and an allocation in one cycle. This happens on back-to-back payload words and on a data word that overruns a full element. The bench judges both by comparing each record and each write address against a scoreboard filled in ahead of the stimulus.

// File: rtl/rbuf_alloc.sv
module rbuf_alloc #(
  parameter int BUF_BYTES = 8192,
  parameter int MIN_ELEM  = 64,
  parameter int OVF_W     = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         cfg_esize,
  input  logic                               in_valid,
  input  logic                               in_ctl,
  input  logic [15:0]                        in_word,
  input  logic                               rel_valid,
  input  logic [$clog2(BUF_BYTES/MIN_ELEM)-1:0] rel_idx,
  output logic                               wr_en,
  output logic [$clog2(BUF_BYTES)-2:0]       wr_addr,
  output logic [15:0]                        wr_data,
  output logic                               done_valid,
  output logic [$clog2(BUF_BYTES/MIN_ELEM)-1:0] done_idx,
  output logic [$clog2(MIN_ELEM*4):0]        done_bytes,
  output logic                               done_sop,
  output logic                               done_eop,
  output logic [7:0]                         done_port,
  output logic [OVF_W-1:0]                   ovf_cnt
);
  localparam int MAX_EL = BUF_BYTES / MIN_ELEM;
  localparam int IDX_W  = $clog2(MAX_EL);
  localparam int BA_W   = $clog2(BUF_BYTES);
  localparam int CNT_W  = $clog2(MIN_ELEM*4) + 1;
  localparam int SH0    = $clog2(MIN_ELEM);

  logic [IDX_W-1:0] fl_mem [MAX_EL];
  logic [IDX_W-1:0] wp, rp;
  logic [IDX_W:0]   fcnt, fresh;
  logic             cur_open, cur_sop;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] cur_cnt;
  logic [7:0]       cur_port;

  wire [1:0]       esel   = (cfg_esize == 2'd3) ? 2'd2 : cfg_esize;
  wire [CNT_W-1:0] cap    = CNT_W'(MIN_ELEM) << esel;
  wire [IDX_W:0]   nelem  = (IDX_W+1)'(MAX_EL) >> esel;
  wire             has_fr = fresh < nelem;
  wire             avail  = has_fr || (fcnt != '0);
  wire [IDX_W-1:0] a_idx  = has_fr ? fresh[IDX_W-1:0] : fl_mem[rp];

  wire is_cw   = in_valid && in_ctl;
  wire is_dat  = in_valid && !in_ctl;
  wire is_pay  = is_cw && in_word[15];
  wire full    = cur_open && (cur_cnt == cap);
  wire need_a  = is_pay || (is_dat && full);
  wire do_a    = need_a && avail;
  wire pop     = do_a && !has_fr;
  wire close   = cur_open && (is_cw || (is_dat && full));
  wire wr_ok   = is_dat && cur_open && (!full || avail);

  wire [IDX_W-1:0] w_idx  = full ? a_idx : cur_idx;
  wire [BA_W-1:0]  w_off  = full ? '0 : BA_W'(cur_cnt);
  wire [BA_W-1:0]  w_byte = (BA_W'(w_idx) << (SH0 + 32'(esel))) + w_off;
  wire             one_b  = is_cw && (in_word[14:13] == 2'b11) && (cur_cnt != '0);

  always_ff @(posedge clk)
    if (rel_valid) fl_mem[wp] <= rel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; fresh <= '0;
      cur_open <= 1'b0; cur_sop <= 1'b0; cur_idx <= '0; cur_cnt <= '0; cur_port <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      done_valid <= 1'b0; done_idx <= '0; done_bytes <= '0;
      done_sop <= 1'b0; done_eop <= 1'b0; done_port <= '0;
      ovf_cnt <= '0;
    end else begin
      wr_en      <= wr_ok;
      wr_addr    <= w_byte[BA_W-1:1];
      wr_data    <= in_word;
      done_valid <= close;
      done_idx   <= cur_idx;
      done_bytes <= one_b ? cur_cnt - 1'b1 : cur_cnt;
      done_sop   <= cur_sop;
      done_eop   <= is_cw && in_word[14];
      done_port  <= cur_port;
      if (need_a && !avail) ovf_cnt <= ovf_cnt + 1'b1;
      if (do_a && has_fr) fresh <= fresh + 1'b1;
      if (rel_valid) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      fcnt <= fcnt + (IDX_W+1)'(rel_valid) - (IDX_W+1)'(pop);
      if (is_cw) begin
        cur_open <= is_pay && avail;
        cur_idx  <= a_idx;
        cur_cnt  <= '0;
        cur_sop  <= in_word[12];
        cur_port <= in_word[11:4];
      end else if (is_dat && cur_open) begin
        if (full) begin
          cur_open <= avail;
          cur_idx  <= a_idx;
          cur_cnt  <= CNT_W'(2);
          cur_sop  <= 1'b0;
        end else begin
          cur_cnt  <= cur_cnt + CNT_W'(2);
        end
      end
    end
  end
endmodule

module rbuf_alloc_chk #(
  parameter int MIN_ELEM = 64,
  parameter int CNT_W    = 9,
  parameter int OVF_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_esize,
  input logic             in_valid,
  input logic             in_ctl,
  input logic [15:0]      in_word,
  input logic             wr_en,
  input logic             done_valid,
  input logic             done_eop,
  input logic [CNT_W-1:0] done_bytes,
  input logic [OVF_W-1:0] ovf_cnt
);
  wire [CNT_W-1:0] cap_q = CNT_W'(MIN_ELEM) << ((cfg_esize == 2'd3) ? 2'd2 : cfg_esize);

  a_r5_close_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(in_valid));
  a_r9_write_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid && !in_ctl));
  a_r6_bytes_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_bytes <= cap_q);
  a_r5_eop_from_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_eop) |-> $past(in_valid && in_ctl && in_word[14]));
  a_r7_ovf_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_cnt - $past(ovf_cnt)) <= OVF_W'(1));
endmodule

bind rbuf_alloc rbuf_alloc_chk #(.MIN_ELEM(MIN_ELEM), .CNT_W(CNT_W), .OVF_W(OVF_W)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_esize(cfg_esize), .in_valid(in_valid), .in_ctl(in_ctl),
  .in_word(in_word), .wr_en(wr_en), .done_valid(done_valid), .done_eop(done_eop),
  .done_bytes(done_bytes), .ovf_cnt(ovf_cnt));

// File: tb/tb_rbuf_alloc.sv
module tb_rbuf_alloc;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_esize = 0;
  logic in_valid = 0, in_ctl = 0, rel_valid = 0;
  logic [15:0] in_word = 0;
  logic [6:0] rel_idx = 0;
  logic wr_en, done_valid, done_sop, done_eop;
  logic [11:0] wr_addr;
  logic [15:0] wr_data, ovf_cnt;
  logic [6:0] done_idx;
  logic [8:0] done_bytes;
  logic [7:0] done_port;

  rbuf_alloc dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [25:0] exp_rec_q[$];
  logic [27:0] exp_wr_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (done_valid) begin
      if (exp_rec_q.size() == 0) check(0, "R5 unexpected record", {6'd0, done_idx, done_bytes, done_sop, done_eop, done_port}, 0);
      else begin
        logic [25:0] e;
        e = exp_rec_q.pop_front();
        check({done_idx, done_bytes, done_sop, done_eop, done_port} == e, "R4 R5 R6 record",
              {done_idx, done_bytes, done_sop, done_eop, done_port}, e);
      end
    end
    if (wr_en) begin
      if (exp_wr_q.size() == 0) check(0, "R9 unexpected write", {4'd0, wr_addr, wr_data}, 0);
      else begin
        logic [27:0] w;
        w = exp_wr_q.pop_front();
        check({wr_addr, wr_data} == w, "R2 write addr/data", {wr_addr, wr_data}, w);
      end
    end
  end

  task automatic exp_rec(input int idx, input int bytes, input bit sop, input bit eop, input int port);
    exp_rec_q.push_back({7'(idx), 9'(bytes), sop, eop, 8'(port)});
  endtask

  task automatic cw(input bit pay, input logic [1:0] eops, input bit sop, input int port,
                    input bit relv = 0, input int ri = 0);
    in_valid = 1; in_ctl = 1; in_word = {pay, eops, sop, 8'(port), 4'h5};
    rel_valid = relv; rel_idx = 7'(ri);
    @(negedge clk);
    in_valid = 0; in_ctl = 0; rel_valid = 0;
  endtask

  task automatic dat(input logic [15:0] d, input bit expw, input int addr);
    if (expw) exp_wr_q.push_back({12'(addr), d});
    in_valid = 1; in_ctl = 0; in_word = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic rel(input int ri);
    rel_valid = 1; rel_idx = 7'(ri);
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
    check(exp_rec_q.size() == 0, "R5 records outstanding", exp_rec_q.size(), 0);
    check(exp_wr_q.size() == 0, "R2 writes outstanding", exp_wr_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!wr_en, "R1 wr_en after reset", wr_en, 0);
    check(!done_valid, "R1 done_valid after reset", done_valid, 0);
    check(ovf_cnt == 0, "R1 ovf_cnt after reset", ovf_cnt, 0);

    // R4 R5 R1: first element is index 0, 8 bytes, closed by idle with EOP
    cw(1, 2'b00, 1, 5);
    for (int k = 0; k < 4; k++) dat(16'hA000 + 16'(k), 1, k);
    exp_rec(0, 8, 1, 1, 5);
    cw(0, 2'b10, 0, 0);
    // R10 record visible one clock after the closing word
    check(done_valid, "R10 record latency", done_valid, 1);
    drain();

    // R5 one-byte end status shared with next SOP; R6 continuation on overrun
    cw(1, 2'b00, 1, 9);
    for (int k = 0; k < 3; k++) dat(16'hB000 + 16'(k), 1, 32 + k);
    exp_rec(1, 5, 1, 1, 9);
    cw(1, 2'b11, 1, 9);
    for (int k = 0; k < 32; k++) dat(16'hC000 + 16'(k), 1, 64 + k);
    exp_rec(2, 64, 1, 0, 9);
    dat(16'hD000, 1, 96);
    exp_rec(3, 2, 0, 1, 9);
    cw(0, 2'b10, 0, 0);
    drain();

    // R3 idle with nothing open; R9 data with no element open
    cw(0, 2'b00, 0, 3);
    dat(16'hE000, 0, 0);
    dat(16'hE001, 0, 0);
    drain();
    check(ovf_cnt == 0, "R3 idle allocates nothing", ovf_cnt, 0);

    // R8 release 0..3, switch to 256-byte elements (R2)
    for (int k = 0; k < 4; k++) rel(k);
    cfg_esize = 2'd2;
    @(negedge clk);
    for (int k = 0; k <= 32; k++) begin
      if (k > 0) exp_rec((k - 1) < 28 ? 4 + k - 1 : k - 1 - 28, (k == 1) ? 4 : 0, 1, 0, k - 1);
      cw(1, 2'b00, 1, k);
      if (k == 0) begin
        dat(16'h1111, 1, 512);
        dat(16'h2222, 1, 513);
      end
    end
    // R7 drop: data not written, counter stepped
    dat(16'hF000, 0, 0);
    cw(0, 2'b10, 0, 0);
    drain();
    check(ovf_cnt == 1, "R7 overflow count", ovf_cnt, 1);

    // R11 release with empty pool: allocation drops, released index usable next
    cw(1, 2'b00, 1, 40, 1, 7);
    cw(0, 2'b00, 0, 0);
    check(ovf_cnt == 2, "R11 empty-pool collision drops", ovf_cnt, 2);
    // R11 release with one queued index: queued one granted, released one next
    cw(1, 2'b00, 1, 41, 1, 10);
    exp_rec(7, 0, 1, 0, 41);
    cw(1, 2'b00, 1, 42);
    exp_rec(10, 0, 1, 1, 42);
    cw(0, 2'b10, 0, 0);
    drain();
    check(ovf_cnt == 2, "R11 no further drops", ovf_cnt, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule